// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host controller read and write a bank of up to 128 byte-wide registers over a four-wire serial link. The host's serial clock, data-in and active-low select are brought into the fast system clock through synchronisers, and every decision is made in that clock domain. The idle level of the serial clock is captured when select falls. Data is sampled on the trailing edge of each serial clock pulse and launched on the leading edge, so both clock polarities with second-edge sampling are served.

Each select window opens with a command byte. Its top bit selects the direction and the remaining seven bits give the starting register. Any number of data bytes may follow. The register pointer moves forward after every byte and wraps at the end of the bank. Writes leave the block as single-cycle strobes on a register-file port. Reads are fetched through the same port one system cycle after a byte boundary. A blocking input from the power supervisor shuts out every access while it is high.

Top module: `spireg_slave`

## Requirements
- R1: The first 8 bits after select falls form the command byte, taken most significant bit first. Its bit 7 set to 1 means write and 0 means read, and bits 6..0 give the starting register address.
- R2: In a write, each data byte (MSB first) is committed by a one-cycle `reg_we_o` pulse, with the byte on `reg_wdata_o` and its register on `reg_addr_o`. No other cycle pulses `reg_we_o`, and `reg_re_o` is never high in the same cycle.
- R3: After each data byte the register address advances by one, and it wraps from 7Fh to 00h. A burst of N bytes therefore touches N consecutive addresses.
- R4: In a read, `reg_re_o` pulses once when the command byte completes and once when each data byte completes. `reg_rdata_i` is taken in that cycle and shifted out MSB first, one bit per leading serial-clock edge.
- R5: The serial clock level at the moment select falls is taken as its idle level. Transfers work with either idle level.
- R6: `spi_miso_oe_o` is high only in the data phase of a read. It stays low during the command byte and drops once select is high. `spi_miso_o` is 0 whenever the enable is low.
- R7: A data byte cut short by select rising is discarded and never written.
- R8: Select rising resets the bit count and phase, so the next window starts with a new command byte.
- R9: While `bus_block_i` is high, no write is committed and the output enable stays low. Any open window is abandoned, and access returns only at the next fall of select with the block low.
- R10: After reset the output enable, write strobe and read strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Host serial clock, asynchronous |
| spi_mosi_i | input | 1 | Host serial data into the block |
| spi_csn_i | input | 1 | Active-low select from the host |
| bus_block_i | input | 1 | Power supervisor access block, active high |
| spi_miso_o | output | 1 | Serial read data |
| spi_miso_oe_o | output | 1 | Output enable for the read data pad |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read fetch strobe |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the cycle of `reg_addr_o` |

## Verification
The bench starts bursts at 7Eh in both directions and checks that the pointer folds to 00h. A design that saturated or spilled into bit 7 would return the wrong bytes or write the wrong registers. It cuts a write off five bits into its second byte, and a design that committed on select rising would corrupt the next register. It raises the power block both across a whole window and briefly inside a window. A design that only gated the strobe, or that resumed mid-window when the block cleared, would then commit a stray write or drive the pad. Both clock polarities are used, and the number of read fetches per burst is counted, so a wrong edge choice or a missing prefetch shows up as shifted or stale read data.

// File: rtl/spireg_pkg.sv
`timescale 1ns/1ps
package spireg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_WR   = 2'd2,
        PH_RD   = 2'd3
    } phase_e;
endpackage

// File: rtl/spireg_sync.sv
`timescale 1ns/1ps
module spireg_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stg_d;
        if (g == 0) begin : g_first
            assign stg_d = d_i;
        end else begin : g_next
            assign stg_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spireg_ctrl.sv
`timescale 1ns/1ps
module spireg_ctrl
    import spireg_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          mosi_s,
    input  logic          csn_s,
    input  logic          blk_i,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic          re_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          miso_o,
    output logic          oe_o
);
    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    typedef struct packed {
        phase_e        ph;
        logic          cpol;
        logic          sclk_p;
        logic          csn_p;
        logic [BCW-1:0] bitc;
        logic [DW-2:0] sh;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          fetch;
        logic [DW-1:0] tx;
        logic          dout;
        logic          oe;
    } st_t;

    st_t st_d, st_q;

    logic          cs_fall;
    logic          lead_edge;
    logic          trail_edge;
    logic [DW-1:0] byte_in;

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.fetch = 1'b0;
        st_d.sclk_p = sclk_s;
        st_d.csn_p  = csn_s;

        cs_fall    = st_q.csn_p && !csn_s;
        lead_edge  = (st_q.sclk_p == st_q.cpol) && (sclk_s != st_q.cpol);
        trail_edge = (st_q.sclk_p != st_q.cpol) && (sclk_s == st_q.cpol);
        byte_in    = {st_q.sh, mosi_s};

        if (st_q.we)    st_d.addr = st_q.addr + 1'b1;
        if (st_q.fetch) st_d.tx   = rdata_i;

        if (csn_s || blk_i) begin
            st_d.ph   = PH_IDLE;
            st_d.bitc = '0;
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
        end else if (cs_fall) begin
            st_d.ph   = PH_CMD;
            st_d.cpol = sclk_s;
            st_d.bitc = '0;
        end else if (st_q.ph != PH_IDLE) begin
            if (lead_edge && st_q.ph == PH_RD) begin
                st_d.dout = st_q.tx[DW-1];
                st_d.tx   = {st_q.tx[DW-2:0], 1'b0};
                st_d.oe   = 1'b1;
            end
            if (trail_edge) begin
                st_d.sh   = byte_in[DW-2:0];
                st_d.bitc = (st_q.bitc == LAST_BIT) ? '0 : st_q.bitc + 1'b1;
                if (st_q.bitc == LAST_BIT) begin
                    case (st_q.ph)
                        PH_CMD: begin
                            st_d.addr = byte_in[AW-1:0];
                            if (byte_in[DW-1]) begin
                                st_d.ph = PH_WR;
                            end else begin
                                st_d.ph    = PH_RD;
                                st_d.fetch = 1'b1;
                            end
                        end
                        PH_WR: begin
                            st_d.we    = 1'b1;
                            st_d.wdata = byte_in;
                        end
                        PH_RD: begin
                            st_d.addr  = st_q.addr + 1'b1;
                            st_d.fetch = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ph     <= PH_IDLE;
            st_q.csn_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o    = st_q.we;
    assign re_o    = st_q.fetch;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign oe_o    = st_q.oe;
    assign miso_o  = st_q.oe ? st_q.dout : 1'b0;

    // R6: enable only inside a read data phase
    p_oe_rd_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> st_q.ph == PH_RD);
    // R6: select high turns the enable off
    p_cs_idle_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !st_q.oe);
    // R9: block suppresses commits
    p_blk_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_i |=> !st_q.we);
    // R9: block suppresses the pad
    p_blk_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_i |=> !st_q.oe);
    // R3: pointer steps after each committed byte
    p_wr_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |=> st_q.addr == $past(st_q.addr) + 1'b1);
    // R2: write and fetch never share a cycle
    p_no_we_re_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.we && st_q.fetch));
endmodule

// File: rtl/spireg_slave.sv
`timescale 1ns/1ps
module spireg_slave #(
    parameter int AW          = 7,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk_i,
    input  logic          spi_mosi_i,
    input  logic          spi_csn_i,
    input  logic          bus_block_i,
    output logic          spi_miso_o,
    output logic          spi_miso_oe_o,
    output logic          reg_we_o,
    output logic          reg_re_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    input  logic [DW-1:0] reg_rdata_i
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] pins_s;

    spireg_sync #(
        .W      (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({spi_sclk_i, spi_mosi_i, spi_csn_i}),
        .q_o  (pins_s)
    );

    spireg_ctrl #(
        .AW(AW),
        .DW(DW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[2]),
        .mosi_s (pins_s[1]),
        .csn_s  (pins_s[0]),
        .blk_i  (bus_block_i),
        .rdata_i(reg_rdata_i),
        .we_o   (reg_we_o),
        .re_o   (reg_re_o),
        .addr_o (reg_addr_o),
        .wdata_o(reg_wdata_o),
        .miso_o (spi_miso_o),
        .oe_o   (spi_miso_oe_o)
    );
endmodule

// File: tb/spireg_slave_tb_top.sv
`timescale 1ns/1ps
module spireg_slave_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       csn = 1'b1;
    logic       blk = 1'b0;
    logic       miso, miso_oe, reg_we, reg_re;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] regs [128];
    logic [7:0] mdl  [128];
    logic [14:0] exp_q [$];
    logic [14:0] mon_e;
    int n_chk = 0;
    int n_bad = 0;
    int re_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spireg_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk_i   (sclk),
        .spi_mosi_i   (mosi),
        .spi_csn_i    (csn),
        .bus_block_i  (blk),
        .spi_miso_o   (miso),
        .spi_miso_oe_o(miso_oe),
        .reg_we_o     (reg_we),
        .reg_re_o     (reg_re),
        .reg_addr_o   (reg_addr),
        .reg_wdata_o  (reg_wdata),
        .reg_rdata_i  (reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];
    always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R7/R9", "unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                mon_e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == mon_e, "R2/R3", "write addr/data",
                      {reg_addr, reg_wdata}, mon_e);
            end
        end
        if (rst_n && reg_re) re_cnt++;
    end

    task automatic bitx(input logic cpol, input logic b, output logic mi, output logic oe);
        @(negedge clk); sclk = ~cpol; mosi = b;
        repeat (HALF - 1) @(negedge clk);
        mi = miso; oe = miso_oe;
        @(negedge clk); sclk = cpol;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic bytex(input logic cpol, input logic [7:0] tx,
                         output logic [7:0] rx, output int oe_n);
        logic mi, oe;
        oe_n = 0;
        for (int i = 7; i >= 0; i--) begin
            bitx(cpol, tx[i], mi, oe);
            rx[i] = mi;
            if (oe) oe_n++;
        end
    endtask

    task automatic cs_open(input logic cpol);
        @(negedge clk); sclk = cpol; mosi = 1'b0;
        repeat (4) @(negedge clk);
        csn = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_close;
        repeat (4) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr_burst(input logic cpol, input logic [6:0] addr, input int n,
                            input logic [7:0] seed);
        logic [7:0] rx, d;
        logic [6:0] a;
        int oe_n;
        a = addr;
        cs_open(cpol);
        bytex(cpol, {1'b1, addr}, rx, oe_n);
        check(oe_n == 0, "R6", "oe during write command", oe_n, 0);
        for (int i = 0; i < n; i++) begin
            d = seed + 8'(i * 37);
            exp_q.push_back({a, d});
            mdl[a] = d;
            bytex(cpol, d, rx, oe_n);
            a = a + 7'd1;
        end
        cs_close();
        check(exp_q.size() == 0, "R2", "pending writes after burst", exp_q.size(), 0);
    endtask

    task automatic rd_burst(input logic cpol, input logic [6:0] addr, input int n,
                            input string req);
        logic [7:0] rx;
        logic [6:0] a;
        int oe_n;
        a = addr;
        cs_open(cpol);
        bytex(cpol, {1'b0, addr}, rx, oe_n);
        check(oe_n == 0, "R6", "oe during read command", oe_n, 0);
        for (int i = 0; i < n; i++) begin
            bytex(cpol, 8'h00, rx, oe_n);
            check(rx == mdl[a], req, "read byte", rx, mdl[a]);
            check(oe_n == 8, "R6", "oe during read data", oe_n, 8);
            a = a + 7'd1;
        end
        cs_close();
        check(miso_oe == 1'b0 && miso == 1'b0, "R6", "pad after select high",
              {miso_oe, miso}, 0);
    endtask

    initial begin : main
        logic [7:0] rx;
        logic mi, oe;
        int oe_n;
        for (int i = 0; i < 128; i++) begin
            regs[i] = 8'(i * 7) ^ 8'hA5;
            mdl[i]  = 8'(i * 7) ^ 8'hA5;
        end
        repeat (5) @(negedge clk);
        check({miso_oe, reg_we, reg_re, miso} == 4'b0, "R10", "outputs in reset",
              {miso_oe, reg_we, reg_re, miso}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({miso_oe, reg_we, reg_re} == 3'b0, "R10", "outputs after reset",
              {miso_oe, reg_we, reg_re}, 0);

        // R1 R2 R5: single write idle-high, read back idle-low
        wr_burst(1'b1, 7'h10, 1, 8'hC3);
        rd_burst(1'b0, 7'h10, 1, "R1/R4/R5");

        // R3: bursts across the wrap point, both polarities
        wr_burst(1'b0, 7'h7E, 4, 8'h11);
        rd_burst(1'b1, 7'h7E, 4, "R3");

        // R4: fetch count for a 3-byte read
        re_cnt = 0;
        rd_burst(1'b1, 7'h40, 3, "R4");
        check(re_cnt == 4, "R4", "fetch pulses", re_cnt, 4);

        // R7: partial second byte is discarded
        cs_open(1'b0);
        bytex(1'b0, {1'b1, 7'h20}, rx, oe_n);
        exp_q.push_back({7'h20, 8'h3C});
        mdl[7'h20] = 8'h3C;
        bytex(1'b0, 8'h3C, rx, oe_n);
        for (int i = 0; i < 5; i++) bitx(1'b0, 1'b1, mi, oe);
        cs_close();
        check(exp_q.size() == 0, "R7", "full byte committed", exp_q.size(), 0);
        // R8: next window starts with a fresh command byte
        rd_burst(1'b0, 7'h20, 2, "R7/R8");

        // R9: block held across a write and a read window
        blk = 1'b1;
        cs_open(1'b1);
        bytex(1'b1, {1'b1, 7'h30}, rx, oe_n);
        bytex(1'b1, 8'h99, rx, oe_n);
        cs_close();
        cs_open(1'b1);
        bytex(1'b1, {1'b0, 7'h30}, rx, oe_n);
        bytex(1'b1, 8'h00, rx, oe_n);
        check(oe_n == 0, "R9", "oe while blocked", oe_n, 0);
        cs_close();
        blk = 1'b0;
        rd_burst(1'b1, 7'h30, 1, "R9");

        // R9: brief block inside a window abandons it
        cs_open(1'b0);
        blk = 1'b1;
        repeat (3) @(negedge clk);
        blk = 1'b0;
        bytex(1'b0, {1'b1, 7'h31}, rx, oe_n);
        bytex(1'b0, 8'h5E, rx, oe_n);
        cs_close();
        rd_burst(1'b0, 7'h31, 1, "R9");
        check(exp_q.size() == 0, "R2", "queue empty at end", exp_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule